// File: doc/BRIEF.md
# Inter-Processor Interrupt Agent

This block is the interrupt agent of one processor in a multi-processor system. The owning processor reaches it through a 32-bit register port. Through that port it can do three things. It can fire one-cycle doorbell pulses toward the other agents. It can see and acknowledge the doorbells that other agents have rung toward it. It can choose which of those doorbells raise its single interrupt line.

There are eleven channels, and each sits at a fixed, sparse bit position in every register. Channel index i (0..10) maps to bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 in that order. Every other bit is reserved. Incoming doorbells are held in a sticky status register, which software clears by writing ones. The status bits are also driven out per channel so that the sending agents can watch them. A separate set of per-channel level inputs is captured into a read-only observation register.

The mask is never written directly. One strobe register sets mask bits and another clears them. The interrupt output is the OR of all status bits whose mask bit is clear. Reads are combinational from the current address. A write takes effect at the clock edge where `bus_wen` is high.

Top module: `ipi_agent`

## Requirements
- R1: Channel i maps to register bit POS[i], with POS = {0,8,9,16,17,18,19,24,25,26,27}. Writes to any other bit have no effect, and those bits read as 0.
- R2: A write to offset 0x00 drives `trig_out[i]` high for exactly one cycle, starting at the edge of the write, for each channel i whose bit is 1. Offset 0x00 reads 0.
- R3: When `irq_in[i]` is high at a clock edge, status bit i is set. The bit stays set after the input drops. Status reads at offset 0x10.
- R4: Writing 1s to offset 0x10 clears the matching status bits. If `irq_in[i]` is high in the same cycle as a clear of bit i, the bit ends up set.
- R5: `irq_o` is high exactly when some status bit has its mask bit clear.
- R6: The mask register reads at offset 0x14 and resets to all live bits set (0x0F0F0301). Writes to offset 0x14 are ignored.
- R7: Writing 1s to offset 0x18 clears the matching mask bits. Writing 1s to offset 0x1C sets them. Both offsets read 0.
- R8: `obs_out[i]` equals status bit i in every cycle, whether that bit was last changed by an input or by a bus clear.
- R9: Offset 0x04 reads `obs_in` as sampled at the last clock edge, spread to the channel positions. Writes to 0x04 are ignored.
- R10: An access whose `bus_addr[1:0]` is nonzero, or whose address matches no register, writes nothing and reads 0.
- R11: After reset, status, triggers and observation are 0, the mask is all set and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 11 | Incoming doorbell per channel |
| obs_in | input | 11 | Observation level per channel |
| trig_out | output | 11 | Outgoing one-cycle doorbell per channel |
| obs_out | output | 11 | Status echo per channel |
| irq_o | output | 1 | Aggregated unmasked interrupt |

## Verification
The bench targets the cycle in which a doorbell arrives while software is clearing the same status bit. A design that lets the clear win would silently lose that doorbell. It checks that trigger pulses last exactly one cycle; a design without the self-clear would hold the outgoing lines high. It writes to reserved bits, misaligned addresses and the read-only mask. A design that decoded loosely would fire channels or unmask interrupts it should not touch. It also drives each mask strobe and confirms that `irq_o` tracks both of them.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam logic [DW-1:0] LIVE_MASK = 32'h0F0F_0301;

    function automatic int count_live();
        int n;
        n = 0;
        for (int b = 0; b < DW; b++) begin
            if (LIVE_MASK[b]) n++;
        end
        return n;
    endfunction

    localparam int NCH = count_live();

    // bit position of the idx-th live channel
    function automatic int chan_pos(input int idx);
        int n;
        int res;
        n = 0;
        res = 0;
        for (int b = 0; b < DW; b++) begin
            if (LIVE_MASK[b]) begin
                if (n == idx) res = b;
                n++;
            end
        end
        return res;
    endfunction

    localparam logic [AW-1:0] OFS_TRIG = 6'h00;
    localparam logic [AW-1:0] OFS_OBS  = 6'h04;
    localparam logic [AW-1:0] OFS_STAT = 6'h10;
    localparam logic [AW-1:0] OFS_MASK = 6'h14;
    localparam logic [AW-1:0] OFS_EN   = 6'h18;
    localparam logic [AW-1:0] OFS_DIS  = 6'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TRIG,
        SEL_OBS,
        SEL_STAT,
        SEL_MASK,
        SEL_EN,
        SEL_DIS
    } reg_sel_e;

    typedef struct packed {
        logic [NCH-1:0] trig;
        logic [NCH-1:0] stat;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] obs;
    } ipi_state_t;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    output reg_sel_e      sel_o
);
    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i[1:0] == 2'b00) begin
            unique case (addr_i)
                OFS_TRIG: sel_o = SEL_TRIG;
                OFS_OBS:  sel_o = SEL_OBS;
                OFS_STAT: sel_o = SEL_STAT;
                OFS_MASK: sel_o = SEL_MASK;
                OFS_EN:   sel_o = SEL_EN;
                OFS_DIS:  sel_o = SEL_DIS;
                default:  sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ipi_gather.sv
module ipi_gather
    import ipi_pkg::*;
(
    input  logic [DW-1:0]  wide_i,
    output logic [NCH-1:0] narrow_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int P = chan_pos(i);
        assign narrow_o[i] = wide_i[P];
    end

    logic unused_reserved;
    assign unused_reserved = ^(wide_i & ~LIVE_MASK);
endmodule

// File: rtl/ipi_spread.sv
module ipi_spread
    import ipi_pkg::*;
(
    input  logic [NCH-1:0] narrow_i,
    output logic [DW-1:0]  wide_o
);
    always_comb begin
        wide_o = '0;
        for (int i = 0; i < NCH; i++) begin
            wide_o[chan_pos(i)] = narrow_i[i];
        end
    end
endmodule

// File: rtl/ipi_core.sv
module ipi_core
    import ipi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wen_i,
    input  reg_sel_e       sel_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [NCH-1:0] irq_in_i,
    input  logic [NCH-1:0] obs_in_i,
    output ipi_state_t     state_o
);
    ipi_state_t state_d, state_q;
    logic [NCH-1:0] clr_d;
    logic trig_wr_d, en_wr_d, dis_wr_d;

    always_comb begin
        trig_wr_d = wen_i && (sel_i == SEL_TRIG);
        en_wr_d   = wen_i && (sel_i == SEL_EN);
        dis_wr_d  = wen_i && (sel_i == SEL_DIS);
        clr_d     = (wen_i && (sel_i == SEL_STAT)) ? wdata_i : '0;

        state_d       = state_q;
        state_d.obs   = obs_in_i;
        state_d.trig  = trig_wr_d ? wdata_i : '0;
        // incoming doorbell wins over a clear in the same cycle
        state_d.stat  = (state_q.stat & ~clr_d) | irq_in_i;
        if (en_wr_d) begin
            state_d.mask = state_q.mask & ~wdata_i;
        end else if (dis_wr_d) begin
            state_d.mask = state_q.mask | wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{trig: '0, stat: '0, mask: '1, obs: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R2: a pulse never outlives the cycle after its write
    a_r2_trig_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr_d |=> (state_q.trig == '0));

    // R3: set bits not being cleared stay set
    a_r3_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.stat & $past(state_q.stat & ~clr_d)) == $past(state_q.stat & ~clr_d)));

    // R6: mask holds unless a strobe register is written
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr_d || dis_wr_d) |=> $stable(state_q.mask));

    // R7: disable strobe leaves written bits masked
    a_r7_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr_d |=> ((state_q.mask & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/ipi_agent.sv
module ipi_agent
    import ipi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wen,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] irq_in,
    input  logic [NCH-1:0] obs_in,
    output logic [NCH-1:0] trig_out,
    output logic [NCH-1:0] obs_out,
    output logic           irq_o
);
    reg_sel_e       sel_w;
    logic [NCH-1:0] wdata_n;
    ipi_state_t     st_w;
    logic [DW-1:0]  stat_wide, mask_wide, obs_wide;

    ipi_decode u_decode (.addr_i(bus_addr), .sel_o(sel_w));

    ipi_gather u_gather (.wide_i(bus_wdata), .narrow_o(wdata_n));

    ipi_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_i    (bus_wen),
        .sel_i    (sel_w),
        .wdata_i  (wdata_n),
        .irq_in_i (irq_in),
        .obs_in_i (obs_in),
        .state_o  (st_w)
    );

    ipi_spread u_sp_stat (.narrow_i(st_w.stat), .wide_o(stat_wide));
    ipi_spread u_sp_mask (.narrow_i(st_w.mask), .wide_o(mask_wide));
    ipi_spread u_sp_obs  (.narrow_i(st_w.obs),  .wide_o(obs_wide));

    always_comb begin
        unique case (sel_w)
            SEL_OBS:  bus_rdata = obs_wide;
            SEL_STAT: bus_rdata = stat_wide;
            SEL_MASK: bus_rdata = mask_wide;
            default:  bus_rdata = '0;
        endcase
    end

    assign trig_out = st_w.trig;
    assign obs_out  = st_w.stat;
    assign irq_o    = |(st_w.stat & ~st_w.mask);

    // R5: the interrupt is never raised without a pending status bit
    a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_w.stat != '0));

    // R1: reserved bits never appear on the read port
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LIVE_MASK) == '0);
endmodule

// File: tb/ipi_agent_bench.sv
`timescale 1ns/1ps
module ipi_agent_bench;
    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] irq_in = '0;
    logic [10:0] obs_in = '0;
    logic [10:0] trig_out, obs_out;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    ipi_agent u_ipi_agent (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .obs_in(obs_in), .trig_out(trig_out), .obs_out(obs_out), .irq_o(irq_o)
    );

    function automatic logic [31:0] spread(input logic [10:0] n);
        int pos [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 11; i++) w[pos[i]] = n[i];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write applied at one edge; returns at the following falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 irq low", {31'b0, irq_o}, 32'h0);
        chk("R11 trig idle", {21'b0, trig_out}, 32'h0);
        chk("R11 obs_out idle", {21'b0, obs_out}, 32'h0);
        rd(6'h14, d); chk("R6 mask reset", d, 32'h0F0F_0301);
        rd(6'h10, d); chk("R11 status reset", d, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        wr(6'h00, 32'hFFFF_FFFF);
        chk("R2 all channels pulse", {21'b0, trig_out}, 32'h7FF);
        @(negedge clk);
        chk("R2 pulse self-clears", {21'b0, trig_out}, 32'h0);
        rd(6'h00, d); chk("R2 trigger reads zero", d, 32'h0);
        wr(6'h00, 32'h0000_0100);
        chk("R1 bit 8 is channel 1", {21'b0, trig_out}, 32'h002);
        wr(6'h00, 32'hF0F0_FCFE);
        chk("R1 reserved trigger bits ignored", {21'b0, trig_out}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        @(negedge clk); irq_in = 11'b100;
        @(negedge clk); irq_in = '0;
        rd(6'h10, d); chk("R3 status latched", d, 32'h0000_0200);
        chk("R8 obs_out follows input-set status", {21'b0, obs_out}, 32'h004);
        repeat (3) @(negedge clk);
        rd(6'h10, d); chk("R3 status sticky", d, 32'h0000_0200);
        chk("R5 masked status keeps irq low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(6'h18, 32'h0000_0200);
        rd(6'h14, d); chk("R7 enable clears mask bit", d, 32'h0F0F_0101);
        chk("R5 unmasked status raises irq", {31'b0, irq_o}, 32'h1);
        rd(6'h18, d); chk("R7 enable reads zero", d, 32'h0);
        wr(6'h1C, 32'h0000_0200);
        chk("R5 remask drops irq", {31'b0, irq_o}, 32'h0);
        rd(6'h1C, d); chk("R7 disable reads zero", d, 32'h0);
        rd(6'h14, d); chk("R7 disable sets mask bit", d, 32'h0F0F_0301);
        wr(6'h14, 32'h0);
        rd(6'h14, d); chk("R6 mask write ignored", d, 32'h0F0F_0301);
        wr(6'h18, 32'h0000_0200);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(6'h10, 32'h0000_0200);
        rd(6'h10, d); chk("R4 status cleared by write-one", d, 32'h0);
        chk("R8 obs_out follows bus clear", {21'b0, obs_out}, 32'h0);
        chk("R5 irq drops after clear", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h1; irq_in = 11'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0; irq_in = '0;
        rd(6'h10, d); chk("R4 set wins over clear", d, 32'h1);
        wr(6'h10, 32'h1);
        rd(6'h10, d); chk("R4 later clear works", d, 32'h0);
    endtask

    task automatic t_obs();
        logic [31:0] d;
        @(negedge clk); obs_in = 11'h7FF;
        @(negedge clk);
        rd(6'h04, d); chk("R9 observation sampled", d, 32'h0F0F_0301);
        wr(6'h04, 32'h0);
        rd(6'h04, d); chk("R9 observation write ignored", d, 32'h0F0F_0301);
        obs_in = 11'b000_0000_0110;
        @(negedge clk);
        rd(6'h04, d); chk("R9 observation follows level", d, spread(11'b110));
        obs_in = '0;
    endtask

    task automatic t_misaligned();
        logic [31:0] d;
        wr(6'h1D, 32'h0000_0200);
        wr(6'h19, 32'h0F0F_0301);
        rd(6'h14, d); chk("R10 misaligned strobe ignored", d, 32'h0F0F_0101);
        wr(6'h01, 32'hFFFF_FFFF);
        chk("R10 misaligned trigger ignored", {21'b0, trig_out}, 32'h0);
        rd(6'h15, d); chk("R10 misaligned read zero", d, 32'h0);
        wr(6'h08, 32'hFFFF_FFFF);
        chk("R10 unmapped write no pulse", {21'b0, trig_out}, 32'h0);
        rd(6'h14, d); chk("R10 unmapped write leaves mask", d, 32'h0F0F_0101);
    endtask

    initial begin
        t_reset();
        t_trigger();
        t_sticky();
        t_mask();
        t_w1c();
        t_obs();
        t_misaligned();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(TCK * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule